// File: doc/BRIEF.md
# Programmable Comma Word Aligner

This block sits behind a deserializer that delivers parallel words whose bit boundary is arbitrary. While its align enable is high and no boundary is held, it searches every bit offset of a window made of the previous and current input words for a programmable pattern. The pattern may be 7, 8, 10, 16, 20 or 32 bits long. The comparison is either exact or also accepts the bitwise complement, so a running-disparity comma such as K28.5 is caught in either polarity. The first hit locks the boundary. From then on every output word is the window shifted so that the pattern lands in the least significant bits.

Once locked, the boundary is held. A sync flag stays high and a detect flag pulses whenever the pattern reappears at the held boundary. A new rising edge of the align enable drops the lock and starts a fresh search. With the enable low, the boundary can be stepped by hand one bit per rising edge of a slip request.

Top module: `comma_word_aligner`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `data_out`, `pat_detect` and `sync_status` are all zero and the boundary offset is 0.
- R2: `pat_len` selects how many low bits of `pattern` take part in the compare: code 0 gives 7, 1 gives 8, 2 gives 10, 3 gives 16, 4 gives 20, 5 gives 32, and codes 6 and 7 give 10. Pattern bits above the selected length are ignored.
- R3: With `match_mode` = 0 only the exact pattern matches. With `match_mode` = 1 a window slice equal to either the pattern or its bitwise complement (over the selected length) matches.
- R4: The search window is {current `data_in`, previous `data_in`}, with the previous word in the low half. An offset k covers window bits k upward, for k = 0..W-1. One cycle after a word is presented, `data_out` equals bits k+W-1..k of that window, where k is the boundary offset in force after that edge.
- R5: When several offsets match in one window, the lowest offset (earliest received bit) is taken and the others are ignored.
- R6: A match found while `align_en` is high, no boundary is held, and the cycle is not an enable rising edge locks that offset. After the edge `sync_status` is 1, `pat_detect` is 1, and the matched pattern sits in the low bits of `data_out`.
- R7: While locked and no restart occurs, matches at other offsets do not move the boundary and `sync_status` stays 1.
- R8: `pat_detect` is 1 for exactly the cycles after a window in which the pattern matches at the locked offset, and is 0 whenever `sync_status` is 0.
- R9: In a cycle where `align_en` rises, any lock is cleared and no lock is taken, even if the window matches. The search runs from the next cycle.
- R10: With `align_en` low, each rising edge of `bitslip` advances the offset by one, wrapping from W-1 to 0, and clears `sync_status`. A held `bitslip` level advances only once.
- R11: While `align_en` is high, `bitslip` has no effect on the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | W | Unaligned parallel word; earlier bits in lower positions |
| align_en | input | 1 | Pattern search enable; rising edge restarts search |
| bitslip | input | 1 | Manual boundary step request, edge-sensitive |
| pattern | input | PMAX | Alignment pattern, right-justified |
| pat_len | input | 3 | Pattern length code (see R2) |
| match_mode | input | 1 | 0 = exact only, 1 = exact or complement |
| data_out | output | W | Aligned word |
| pat_detect | output | 1 | Pattern seen at locked boundary |
| sync_status | output | 1 | Boundary locked |

## Verification
Two functions can fall in one cycle. A restart edge on `align_en` can coincide with a window that already holds the pattern, and a `bitslip` edge can arrive while the search enable is high. The bench provokes the first by presenting the second half of a straddling comma in the very cycle the enable rises. It then expects `sync_status` low after that edge and a lock only when the comma is sent again. For the second, it pulses `bitslip` during a search that finds nothing, then reads the offset back through `data_out` once the enable falls.

// File: rtl/cwa_pkg.sv
package cwa_pkg;

    typedef enum logic [2:0] {
        LEN_7   = 3'd0,
        LEN_8   = 3'd1,
        LEN_10  = 3'd2,
        LEN_16  = 3'd3,
        LEN_20  = 3'd4,
        LEN_32  = 3'd5,
        LEN_R6  = 3'd6,
        LEN_R7  = 3'd7
    } len_code_e;

    typedef enum logic {
        MATCH_EXACT  = 1'b0,
        MATCH_EITHER = 1'b1
    } match_mode_e;

    // Number of compared pattern bits for a length code (R2)
    function automatic int unsigned pat_width(input logic [2:0] code);
        case (len_code_e'(code))
            LEN_7:   return 7;
            LEN_8:   return 8;
            LEN_10:  return 10;
            LEN_16:  return 16;
            LEN_20:  return 20;
            LEN_32:  return 32;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/cwa_match.sv
// Compares the pattern against every candidate offset of the window.
module cwa_match #(
    parameter int W    = 32,
    parameter int PMAX = 32
) (
    input  logic [2*W-1:0]  win,
    input  logic [PMAX-1:0] pattern,
    input  logic [PMAX-1:0] pmask,
    input  logic            either_pol,
    output logic [W-1:0]    hits
);
    localparam int WIN = 2 * W;
    localparam int EXT = WIN + PMAX;

    logic [EXT-1:0] ext;
    assign ext = {{PMAX{1'b0}}, win};

    for (genvar k = 0; k < W; k++) begin : g_off
        logic [PMAX-1:0] seg;
        logic            same_hit;
        logic            inv_hit;
        assign seg      = ext[k +: PMAX];
        assign same_hit = ~|((seg ^ pattern) & pmask);
        assign inv_hit  = ~|((seg ^ ~pattern) & pmask);
        assign hits[k]  = same_hit | (either_pol & inv_hit);
    end

endmodule

// File: rtl/cwa_first.sv
// Picks the lowest set position of the hit vector.
module cwa_first #(
    parameter int W    = 32,
    parameter int OFFW = 5
) (
    input  logic [W-1:0]    hits,
    output logic            found,
    output logic [OFFW-1:0] first
);
    always_comb begin
        found = |hits;
        first = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (hits[i]) begin
                first = OFFW'(i);
            end
        end
    end

endmodule

// File: rtl/cwa_shift.sv
// Logarithmic right shifter of the two-word window.
module cwa_shift #(
    parameter int W    = 32,
    parameter int OFFW = 5
) (
    input  logic [2*W-1:0]  win,
    input  logic [OFFW-1:0] amt,
    output logic [W-1:0]    aligned
);
    localparam int WIN = 2 * W;

    logic [WIN-1:0] stage [OFFW+1];

    assign stage[0] = win;

    for (genvar s = 0; s < OFFW; s++) begin : g_stage
        assign stage[s+1] = amt[s] ? (stage[s] >> (1 << s)) : stage[s];
    end

    assign aligned = stage[OFFW][W-1:0];

endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner
    import cwa_pkg::*;
#(
    parameter int W    = 32,
    parameter int PMAX = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [W-1:0]    data_in,
    input  logic            align_en,
    input  logic            bitslip,
    input  logic [PMAX-1:0] pattern,
    input  logic [2:0]      pat_len,
    input  logic            match_mode,
    output logic [W-1:0]    data_out,
    output logic            pat_detect,
    output logic            sync_status
);
    localparam int OFFW = (W > 1) ? $clog2(W) : 1;
    localparam int WIN  = 2 * W;
    localparam int CW   = (W < PMAX) ? W : PMAX;

    typedef struct packed {
        logic [W-1:0]    prev;
        logic [OFFW-1:0] off;
        logic            locked;
        logic            en_q;
        logic            bs_q;
        logic [W-1:0]    dout;
        logic            pdet;
    } state_t;

    state_t q, d;

    logic [WIN-1:0]  win;
    logic [PMAX-1:0] pmask;
    logic [W-1:0]    hits;
    logic            found;
    logic [OFFW-1:0] first_off;
    logic            en_rise;
    logic            slip_rise;
    logic            slip_act;
    logic            restart;
    logic            take_lock;
    logic [OFFW-1:0] off_nxt;
    logic            lock_nxt;
    logic [W-1:0]    shifted;

    assign win = {data_in, q.prev};

    // Compare mask from the length code (R2)
    always_comb begin
        int unsigned len;
        len = pat_width(pat_len);
        for (int i = 0; i < PMAX; i++) begin
            pmask[i] = (i < int'(len));
        end
    end

    cwa_match #(.W(W), .PMAX(PMAX)) u_match (
        .win        (win),
        .pattern    (pattern),
        .pmask      (pmask),
        .either_pol (match_mode == MATCH_EITHER),
        .hits       (hits)
    );

    cwa_first #(.W(W), .OFFW(OFFW)) u_first (
        .hits  (hits),
        .found (found),
        .first (first_off)
    );

    // Boundary control: restart, lock capture and manual slip
    always_comb begin
        en_rise   = align_en & ~q.en_q;
        slip_rise = bitslip & ~q.bs_q;
        slip_act  = slip_rise & ~align_en;
        restart   = en_rise | slip_act;
        take_lock = align_en & ~q.locked & ~en_rise & found;

        off_nxt  = q.off;
        lock_nxt = q.locked;
        if (en_rise) begin
            lock_nxt = 1'b0;
        end else if (take_lock) begin
            lock_nxt = 1'b1;
            off_nxt  = first_off;
        end else if (slip_act) begin
            lock_nxt = 1'b0;
            off_nxt  = (q.off == OFFW'(W - 1)) ? '0 : q.off + 1'b1;
        end
    end

    cwa_shift #(.W(W), .OFFW(OFFW)) u_shift (
        .win     (win),
        .amt     (off_nxt),
        .aligned (shifted)
    );

    // Next-state assembly
    always_comb begin
        d        = q;
        d.prev   = data_in;
        d.en_q   = align_en;
        d.bs_q   = bitslip;
        d.off    = off_nxt;
        d.locked = lock_nxt;
        d.dout   = shifted;
        d.pdet   = lock_nxt & hits[off_nxt];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign data_out    = q.dout;
    assign pat_detect  = q.pdet;
    assign sync_status = q.locked;

    // ---------------- assertions ----------------
    assert_offset_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q.off) < W);

    assert_lowest_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ((hits & ~({W{1'b1}} << first_off)) == '0) && hits[first_off]);

    assert_lock_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_status) |-> pat_detect);

    assert_lock_lsb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_status) |->
            (((data_out[CW-1:0] ^ $past(pattern[CW-1:0])) & $past(pmask[CW-1:0])) == '0) ||
            ($past(match_mode) &&
             (((data_out[CW-1:0] ^ ~$past(pattern[CW-1:0])) & $past(pmask[CW-1:0])) == '0)));

    assert_hold_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.locked && !restart) |=> ($stable(q.off) && sync_status));

    assert_detect_needs_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pat_detect |-> sync_status);

    assert_drop_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_status) |-> $past(restart));

    assert_no_lock_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> !sync_status);

    assert_slip_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (align_en && q.en_q && !q.locked && !found) |=> $stable(q.off));

endmodule

// File: tb/test_comma_word_aligner.sv
module test_comma_word_aligner;
    localparam int W    = 32;
    localparam int PMAX = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [W-1:0]    data_in;
    logic            align_en;
    logic            bitslip;
    logic [PMAX-1:0] pattern;
    logic [2:0]      pat_len;
    logic            match_mode;
    logic [W-1:0]    data_out;
    logic            pat_detect;
    logic            sync_status;

    always #2 clk = ~clk;

    comma_word_aligner #(.W(W), .PMAX(PMAX)) i_comma_word_aligner (
        .clk, .rst_n, .data_in, .align_en, .bitslip, .pattern,
        .pat_len, .match_mode, .data_out, .pat_detect, .sync_status
    );

    int  vectors = 0;
    int  errs    = 0;
    bit  done    = 0;

    // reference state, built from the requirements
    logic [W-1:0] m_prev;
    int           m_off;
    bit           m_lock, m_en, m_bs, m_pdet;
    logic [W-1:0] m_dout;
    logic [31:0]  rng = 32'h1357_9bdf;

    function automatic int len_of(input logic [2:0] c);
        case (c)
            3'd0: return 7;   3'd1: return 8;   3'd2: return 10;
            3'd3: return 16;  3'd4: return 20;  3'd5: return 32;
            default: return 10;
        endcase
    endfunction

    function automatic logic [31:0] mask_of(input int n);
        logic [31:0] m = '0;
        for (int i = 0; i < 32; i++) if (i < n) m[i] = 1'b1;
        return m;
    endfunction

    function automatic bit hit_at(input logic [63:0] w, input int k);
        logic [31:0] seg = 32'(w >> k);
        logic [31:0] m   = mask_of(len_of(pat_len));
        bit same = (((seg ^ pattern) & m) == 0);
        bit inv  = (((seg ^ ~pattern) & m) == 0);
        return same || (match_mode && inv);
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic [W-1:0] din, input bit en, input bit bs);
        logic [63:0] w;
        bit er, sa;
        int first;
        @(negedge clk);
        data_in  = din;
        align_en = en;
        bitslip  = bs;
        w     = {din, m_prev};
        first = -1;
        for (int k = W - 1; k >= 0; k--) if (hit_at(w, k)) first = k;
        er = en && !m_en;
        sa = bs && !m_bs && !en;
        if (er) m_lock = 0;
        else if (en && !m_lock && first >= 0) begin m_lock = 1; m_off = first; end
        else if (sa) begin m_lock = 0; m_off = (m_off + 1) % W; end
        m_dout = 32'(w >> m_off);
        m_pdet = m_lock && hit_at(w, m_off);
        m_prev = din; m_en = en; m_bs = bs;
        @(posedge clk);
        #1;
        check(data_out === m_dout, "R4 data_out", 64'(data_out), 64'(m_dout));
        check(pat_detect === m_pdet, "R8 pat_detect", 64'(pat_detect), 64'(m_pdet));
        check(sync_status === m_lock, "R6 sync_status", 64'(sync_status), 64'(m_lock));
    endtask

    task automatic set_cfg(input logic [31:0] p, input logic [2:0] c, input bit md);
        @(negedge clk);
        pattern = p; pat_len = c; match_mode = md;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        logic [63:0] s, s2;
        logic [31:0] p, ins, msk, a, b;
        int L, k2;

        rst_n = 0; data_in = '0; align_en = 0; bitslip = 0;
        pattern = '0; pat_len = 3'd2; match_mode = 0;
        m_prev = '0; m_off = 0; m_lock = 0; m_en = 0; m_bs = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(data_out === '0, "R1 data_out", 64'(data_out), 0);
        check(pat_detect === 1'b0, "R1 pat_detect", 64'(pat_detect), 0);
        check(sync_status === 1'b0, "R1 sync_status", 64'(sync_status), 0);
        @(negedge clk); rst_n = 1;

        // sweep: every length code, both modes, every offset
        for (int c = 0; c < 8; c++) begin
            for (int md = 0; md < 2; md++) begin
                for (int k = 0; k < W; k++) begin
                    L   = len_of(3'(c));
                    msk = mask_of(L);
                    rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
                    p   = (rng & msk) | 32'h1 | (32'h1 << (L - 1));
                    ins = md ? (~p & msk) : p;
                    set_cfg(p, 3'(c), md[0]);
                    s = 64'(ins) << k;
                    step('0, 0, 0);
                    step('0, 1, 0);
                    step('0, 1, 0);
                    step(s[31:0], 1, 0);
                    step(s[63:32], 1, 0);
                    check(sync_status === 1'b1, "R6 R3 lock", 64'(sync_status), 1);
                    if (md == 0) begin
                        check(data_out === ins, "R2 R4 aligned", 64'(data_out), 64'(ins));
                        k2 = (k + 7) % W;
                        s2 = 64'(ins) << k2;
                        step(s2[31:0], 1, 0);
                        step(s2[63:32], 1, 0);
                        check(data_out === 32'(s2 >> k), "R7 held", 64'(data_out), 64'(32'(s2 >> k)));
                        check(sync_status === 1'b1, "R7 sync", 64'(sync_status), 1);
                        step(s[31:0], 1, 0);
                        step(s[63:32], 1, 0);
                        check(pat_detect === 1'b1, "R8 pulse", 64'(pat_detect), 1);
                        step('0, 1, 0);
                        check(pat_detect === 1'b0, "R8 no pulse", 64'(pat_detect), 0);
                    end
                end
            end
        end

        // R2: bits above selected length ignored (code 6 -> 10 bits)
        set_cfg(32'h0003_FF81 | 32'h3000_0000, 3'd6, 0);
        s = 64'(32'h381) << 5;
        step('0, 0, 0); step('0, 1, 0); step('0, 1, 0);
        step(s[31:0], 1, 0); step(s[63:32], 1, 0);
        check(sync_status === 1'b1 && data_out === 32'h381, "R2 code6",
              64'(data_out), 64'h381);

        // R5: two copies in one window, lowest wins
        set_cfg(32'h81, 3'd1, 0);
        s = (64'h81 << 3) | (64'h81 << 20);
        step('0, 0, 0); step('0, 1, 0); step('0, 1, 0);
        step(s[31:0], 1, 0); step(s[63:32], 1, 0);
        check(data_out === 32'(s >> 3), "R5 lowest", 64'(data_out), 64'(32'(s >> 3)));

        // R10: manual slip, single step per edge, wraparound
        a = 32'hA5C3_1E0F; b = 32'h3C96_F00D;
        step('0, 0, 0);
        step('0, 0, 1);
        check(sync_status === 1'b0, "R10 slip clears sync", 64'(sync_status), 0);
        step(a, 0, 0); step(b, 0, 0);
        check(data_out === 32'({b, a} >> 4), "R10 step", 64'(data_out), 64'(32'({b, a} >> 4)));
        step('0, 0, 1); step('0, 0, 1); step('0, 0, 1);
        step(a, 0, 0); step(b, 0, 0);
        check(data_out === 32'({b, a} >> 5), "R10 level", 64'(data_out), 64'(32'({b, a} >> 5)));
        for (int i = 0; i < 27; i++) begin step('0, 0, 1); step('0, 0, 0); end
        step(a, 0, 0); step(b, 0, 0);
        check(data_out === a, "R10 wrap", 64'(data_out), 64'(a));

        // R11: slip pulses during an unsuccessful search
        step('0, 1, 0); step('0, 1, 1); step('0, 1, 0); step('0, 1, 1);
        step(a, 0, 0); step(b, 0, 0);
        check(data_out === a, "R11 slip ignored", 64'(data_out), 64'(a));

        // R9: enable rising edge in the same cycle as a straddling comma
        set_cfg(32'h0FA, 3'd2, 0);
        s = 64'h0FA << 28;
        step('0, 0, 0);
        step(s[31:0], 0, 0);
        step(s[63:32], 1, 0);
        check(sync_status === 1'b0, "R9 rise beats match", 64'(sync_status), 0);
        step('0, 1, 0);
        step(s[31:0], 1, 0); step(s[63:32], 1, 0);
        check(sync_status === 1'b1 && data_out === 32'h0FA, "R9 relock",
              64'(data_out), 64'h0FA);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule